// File: doc/BRIEF.md
# Rate-adaptive Rijndael round-key scheduler

This block supplies a Rijndael round datapath with one round key per clock cycle. The key is as wide as the chosen data block: 4, 6 or 8 32-bit words. The key expansion runs in steps of one cipher-key width, which is 4, 6 or 8 words. When the block and key lengths differ, one expansion step per cycle is not the right pace. The scheduler therefore keeps three consecutive expansion results (older, middle, newest). Two expansion stages are chained behind the newest result, so each cycle the scheduler can move forward by zero, one or two steps.

A word offset, kept modulo the key width, marks where the next round key starts inside the joined three results. Each delivered key moves that offset forward by the block width. The carry out of the modulo sets how many expansion steps are taken in that cycle. Some pairings need a fractional average, such as 1.5 steps per round key for a 6-word block with a 4-word key. These pairings alternate their step count and never stall the output.

A start pulse loads the cipher key and captures the two length selects. An advance enable then steps through the round keys, one per cycle.

Top module: `keysched_pacer`

## Requirements
- R1: While reset is asserted and afterwards until the first start pulse, `rkey_valid` is 0 and `rkey` is all zeros.
- R2: One cycle after a start pulse, `rkey_valid` is 1 and `rkey` holds the first Nb words of the cipher key. Word i of any 256-bit bus sits at bits [255-32i -: 32], and the Nk key words occupy the top of `key_in`. Bits of `rkey` above word Nb-1 are zero.
- R3: The length selects use the code 0 = 4 words (128 bits), 1 = 6 words, 2 = 8 words and 3 = 8 words. They are captured only on a start pulse, and later changes have no effect until the next start.
- R4: At each clock edge with `rkey_valid` and `adv_en` high and `start` low, the round key moves to the next Nb words of the expanded-key word stream. After t such steps, `rkey` holds stream words t·Nb to t·Nb+Nb-1.
- R5: The expanded stream follows Rijndael key expansion. Each new step rotates the last previous word, substitutes its bytes, and XORs the round constant into its top byte. For 8-word keys, word 4 of each step is also substituted. Round constants start at 0x01 and are doubled in GF(2^8) modulo 0x11B.
- R6: With `adv_en` low (and no start), `rkey` and `rkey_valid` hold their values.
- R7: Every one of the nine key/block length pairings delivers a new correct round key on each enabled cycle with no stall. This includes pairings that need two expansion steps in one cycle (8-word block, 4-word key) and pairings with alternating step counts (6-word block, 4-word key).
- R8: A start pulse while round keys are running restarts from round 0 with the new key and lengths, and takes priority over `adv_en`.
- R9: `adv_en` before the first start has no effect: `rkey_valid` stays 0 and `rkey` stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load cipher key and capture length selects |
| adv_en | input | 1 | Step to the next round key this cycle |
| nk_sel | input | 2 | Cipher key length code |
| nb_sel | input | 2 | Data block length code |
| key_in | input | 256 | Cipher key, word 0 in the top 32 bits |
| rkey | output | 256 | Current round key, word 0 in the top 32 bits |
| rkey_valid | output | 1 | Round key is valid |

## Verification
The bench builds the block with its package defaults: 32-bit words and up to 8 words per key and per block. These defaults make all nine length pairings and the spare select code reachable. Among them are the two-step pairing, the alternating 1/2-step pairing and the pairings where no step is taken on some cycles. Every round key is compared with an expanded-key stream that the bench computes itself. The bench's S-box is generated by a different construction from the one in the design, and a published 128-bit key vector anchors both. Stalls, selects changed mid-run, a restart during an advance, and advance before the first start cover the hold and priority rules.

// File: rtl/ks_pkg.sv
package ks_pkg;
    localparam int WORD_W  = 32;
    localparam int MAX_W   = 8;
    localparam int KEY_W   = WORD_W * MAX_W;
    localparam int CAT_W   = 3 * MAX_W;
    localparam int OFF_W   = $clog2(MAX_W);
    localparam int CNT_W   = OFF_W + 1;
    localparam int N_STAGE = 2;

    typedef logic [WORD_W-1:0] word_t;
    typedef word_t [MAX_W-1:0] sub_t;

    typedef struct packed {
        logic [CNT_W-1:0] nk;
        logic [CNT_W-1:0] nb;
    } geom_t;

    function automatic logic [7:0] xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] x;
        acc = '0;
        x   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ x;
            x = xtime(x);
        end
        return acc;
    endfunction

    // x^254 = multiplicative inverse (0 maps to 0)
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] r;
        logic [7:0] p;
        r = 8'h01;
        p = a;
        for (int i = 0; i < 8; i++) begin
            if (i != 0) r = gf_mul(r, p);
            p = gf_mul(p, p);
        end
        return r;
    endfunction

    function automatic logic [7:0] sbox(input logic [7:0] a);
        logic [7:0] v;
        v = gf_inv(a);
        return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
                 ^ {v[3:0], v[7:4]} ^ 8'h63;
    endfunction

    function automatic word_t sub_word(input word_t w);
        word_t r;
        for (int b = 0; b < 4; b++) r[8*b +: 8] = sbox(w[8*b +: 8]);
        return r;
    endfunction

    function automatic word_t rot_word(input word_t w);
        return {w[WORD_W-9:0], w[WORD_W-1 -: 8]};
    endfunction

    function automatic logic [CNT_W-1:0] len_words(input logic [1:0] sel);
        case (sel)
            2'd0:    return CNT_W'(4);
            2'd1:    return CNT_W'(6);
            default: return CNT_W'(8);
        endcase
    endfunction
endpackage

// File: rtl/ks_expand_stage.sv
module ks_expand_stage
    import ks_pkg::*;
(
    input  sub_t             din,
    input  logic [CNT_W-1:0] nk,
    input  logic [7:0]       rc,
    output sub_t             dout
);
    word_t last;
    word_t acc;

    always_comb begin
        case (nk)
            CNT_W'(4): last = din[3];
            CNT_W'(6): last = din[5];
            default:   last = din[7];
        endcase
        acc = sub_word(rot_word(last)) ^ {rc, 24'h0};
        for (int i = 0; i < MAX_W; i++) begin
            if (i == 4 && nk == CNT_W'(8)) acc = sub_word(acc);
            acc = acc ^ din[i];
            dout[i] = (i < int'(nk)) ? acc : '0;
        end
    end
endmodule

// File: rtl/ks_window.sv
module ks_window
    import ks_pkg::*;
(
    input  sub_t             prev_w,
    input  sub_t             cur_w,
    input  sub_t             next_w,
    input  logic [CNT_W-1:0] nk,
    input  logic [CNT_W-1:0] nb,
    input  logic [OFF_W-1:0] offs,
    output logic [KEY_W-1:0] rkey
);
    word_t cat [CAT_W];

    always_comb begin
        for (int i = 0; i < CAT_W; i++) begin
            if (i < int'(nk))
                cat[i] = prev_w[OFF_W'(i)];
            else if (i < 2 * int'(nk))
                cat[i] = cur_w[OFF_W'(i - int'(nk))];
            else if (i < 3 * int'(nk))
                cat[i] = next_w[OFF_W'(i - 2 * int'(nk))];
            else
                cat[i] = '0;
        end
        for (int j = 0; j < MAX_W; j++) begin
            rkey[KEY_W-1-WORD_W*j -: WORD_W] =
                (j < int'(nb)) ? cat[int'(offs) + j] : '0;
        end
    end
endmodule

// File: rtl/ks_ctrl.sv
module ks_ctrl
    import ks_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             adv_en,
    input  logic [1:0]       nk_sel,
    input  logic [1:0]       nb_sel,
    output geom_t            geom_q,
    output logic [OFF_W-1:0] offs_q,
    output logic             valid_q,
    output logic [1:0]       adv,
    output logic [7:0]       rc_q
);
    logic [CNT_W:0] sum;
    logic [CNT_W:0] nk_x1;
    logic [CNT_W:0] nk_x2;
    logic [CNT_W:0] off_nxt;
    logic [1:0]     adv_raw;
    logic           go;

    always_comb begin
        go    = valid_q && adv_en && !start;
        sum   = (CNT_W+1)'(offs_q) + (CNT_W+1)'(geom_q.nb);
        nk_x1 = (CNT_W+1)'(geom_q.nk);
        nk_x2 = {geom_q.nk, 1'b0};
        if (sum >= nk_x2) begin
            adv_raw = 2'd2;
            off_nxt = sum - nk_x2;
        end else if (sum >= nk_x1) begin
            adv_raw = 2'd1;
            off_nxt = sum - nk_x1;
        end else begin
            adv_raw = 2'd0;
            off_nxt = sum;
        end
        adv = go ? adv_raw : 2'd0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            geom_q  <= '{nk: CNT_W'(4), nb: CNT_W'(4)};
            offs_q  <= '0;
            valid_q <= 1'b0;
            rc_q    <= '0;
        end else if (start) begin
            geom_q  <= '{nk: len_words(nk_sel), nb: len_words(nb_sel)};
            offs_q  <= '0;
            valid_q <= 1'b1;
            rc_q    <= 8'h04;
        end else if (go) begin
            offs_q <= OFF_W'(off_nxt);
            case (adv_raw)
                2'd1:    rc_q <= xtime(rc_q);
                2'd2:    rc_q <= xtime(xtime(rc_q));
                default: rc_q <= rc_q;
            endcase
        end
    end
endmodule

// File: rtl/keysched_pacer.sv
module keysched_pacer
    import ks_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             adv_en,
    input  logic [1:0]       nk_sel,
    input  logic [1:0]       nb_sel,
    input  logic [KEY_W-1:0] key_in,
    output logic [KEY_W-1:0] rkey,
    output logic             rkey_valid
);
    geom_t            geom_q;
    logic [OFF_W-1:0] offs_q;
    logic [1:0]       adv;
    logic [7:0]       rc_q;
    logic [CNT_W-1:0] nk_now;
    sub_t             key_w;
    sub_t             prev_q, cur_q, next_q;
    sub_t             stg [N_STAGE+1];
    logic [7:0]       stg_rc [N_STAGE];

    ks_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start), .adv_en(adv_en),
        .nk_sel(nk_sel), .nb_sel(nb_sel),
        .geom_q(geom_q), .offs_q(offs_q), .valid_q(rkey_valid),
        .adv(adv), .rc_q(rc_q)
    );

    always_comb begin
        for (int i = 0; i < MAX_W; i++)
            key_w[i] = key_in[KEY_W-1-WORD_W*i -: WORD_W];
    end

    assign nk_now    = start ? len_words(nk_sel) : geom_q.nk;
    assign stg[0]    = start ? key_w : next_q;
    assign stg_rc[0] = start ? 8'h01 : rc_q;

    // chained expansion steps behind the newest result
    for (genvar g = 0; g < N_STAGE; g++) begin : g_stage
        if (g > 0) begin : g_rc
            assign stg_rc[g] = xtime(stg_rc[g-1]);
        end
        ks_expand_stage u_exp (
            .din(stg[g]), .nk(nk_now), .rc(stg_rc[g]), .dout(stg[g+1])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            cur_q  <= '0;
            next_q <= '0;
        end else if (start) begin
            prev_q <= key_w;
            cur_q  <= stg[1];
            next_q <= stg[2];
        end else begin
            case (adv)
                2'd1: begin
                    prev_q <= cur_q;
                    cur_q  <= next_q;
                    next_q <= stg[1];
                end
                2'd2: begin
                    prev_q <= next_q;
                    cur_q  <= stg[1];
                    next_q <= stg[2];
                end
                default: ;
            endcase
        end
    end

    ks_window u_win (
        .prev_w(prev_q), .cur_w(cur_q), .next_w(next_q),
        .nk(geom_q.nk), .nb(geom_q.nb), .offs(offs_q), .rkey(rkey)
    );
endmodule

// File: rtl/ks_pacer_chk.sv
module ks_pacer_chk
    import ks_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             adv_en,
    input logic             rkey_valid,
    input logic [KEY_W-1:0] rkey,
    input logic [OFF_W-1:0] offs,
    input logic [CNT_W-1:0] nk,
    input logic [CNT_W-1:0] nb
);
    p_start_valid_r2: assert property (@(posedge clk) disable iff (rst)
        start |=> rkey_valid);

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (rkey_valid && !adv_en && !start) |=> (rkey_valid && $stable(rkey)));

    p_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (!rkey_valid && !start) |=> (!rkey_valid && rkey == '0));

    p_offs_in_key_r4: assert property (@(posedge clk) disable iff (rst)
        rkey_valid |-> (CNT_W'(offs) < nk));

    p_geom_held_r3: assert property (@(posedge clk) disable iff (rst)
        (rkey_valid && !start) |=> ($stable(nk) && $stable(nb)));
endmodule

bind keysched_pacer ks_pacer_chk chk_i (
    .clk(clk), .rst(rst), .start(start), .adv_en(adv_en),
    .rkey_valid(rkey_valid), .rkey(rkey), .offs(offs_q),
    .nk(geom_q.nk), .nb(geom_q.nb)
);

// File: tb/keysched_pacer_tb_top.sv
module keysched_pacer_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         adv_en = 1'b0;
    logic [1:0]   nk_sel = 2'd0;
    logic [1:0]   nb_sel = 2'd0;
    logic [255:0] key_in = '0;
    logic [255:0] rkey;
    logic         rkey_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [255:0] KEY_A =
        256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f;
    localparam logic [255:0] KEY_B =
        256'h8e73b0f7da0e6452c810f32b809079e562f8ead2522c6b7b603deb1015ca71be;
    localparam logic [255:0] KEY_C =
        256'h2b7e151628aed2a6abf7158809cf4f3c00000000000000000000000000000000;

    always #4 clk = ~clk;

    keysched_pacer dut_i (
        .clk(clk), .rst(rst), .start(start), .adv_en(adv_en),
        .nk_sel(nk_sel), .nb_sel(nb_sel), .key_in(key_in),
        .rkey(rkey), .rkey_valid(rkey_valid)
    );

    // ---------------- reference model ----------------
    logic [7:0]  sb [256];
    logic [31:0] w  [200];
    int m_nk, m_nb;

    function automatic logic [7:0] rl(input logic [7:0] v, input int n);
        return (v << n) | (v >> (8 - n));
    endfunction

    task automatic build_sbox();
        logic [7:0] p, q, x;
        p = 8'h01;
        q = 8'h01;
        repeat (255) begin
            p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
            q = q ^ {q[6:0], 1'b0};
            q = q ^ {q[5:0], 2'b00};
            q = q ^ {q[3:0], 4'b0000};
            if (q[7]) q = q ^ 8'h09;
            x = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4);
            sb[p] = x ^ 8'h63;
        end
        sb[0] = 8'h63;
    endtask

    function automatic int sel_words(input logic [1:0] s);
        return (s == 2'd0) ? 4 : (s == 2'd1) ? 6 : 8;
    endfunction

    function automatic logic [31:0] subw(input logic [31:0] v);
        return {sb[v[31:24]], sb[v[23:16]], sb[v[15:8]], sb[v[7:0]]};
    endfunction

    task automatic build_model(input logic [1:0] ks, input logic [1:0] bs,
                               input logic [255:0] key);
        logic [31:0] t;
        logic [7:0]  rc;
        m_nk = sel_words(ks);
        m_nb = sel_words(bs);
        for (int i = 0; i < m_nk; i++) w[i] = key[255-32*i -: 32];
        rc = 8'h01;
        for (int i = m_nk; i < 200; i++) begin
            t = w[i-1];
            if (i % m_nk == 0) begin
                t = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
                rc = {rc[6:0], 1'b0} ^ (rc[7] ? 8'h1b : 8'h00);
            end else if (m_nk == 8 && i % 8 == 4) begin
                t = subw(t);
            end
            w[i] = w[i-m_nk] ^ t;
        end
    endtask

    function automatic logic [255:0] exp_rk(input int t);
        logic [255:0] r;
        r = '0;
        for (int j = 0; j < m_nb; j++) r[255-32*j -: 32] = w[t*m_nb + j];
        return r;
    endfunction

    // ---------------- checking helpers ----------------
    task automatic chk(input string tag, input logic [255:0] act,
                       input logic [255:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
        end
    endtask

    task automatic do_start(input logic [1:0] ks, input logic [1:0] bs,
                            input logic [255:0] key);
        @(negedge clk);
        nk_sel = ks; nb_sel = bs; key_in = key;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", 256'(rkey_valid), 256'(0));
        rst = 1'b0;
        @(negedge clk);
        chk("R1 rkey after reset", rkey, '0);
    endtask

    task automatic t_pre_start();
        adv_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 valid with adv before start", 256'(rkey_valid), 256'(0));
        chk("R9 rkey with adv before start", rkey, '0);
        adv_en = 1'b0;
    endtask

    task automatic t_run(input logic [1:0] ks, input logic [1:0] bs,
                         input logic [255:0] key, input int n);
        build_model(ks, bs, key);
        do_start(ks, bs, key);
        chk("R2 valid after start", 256'(rkey_valid), 256'(1));
        chk("R2 first round key", rkey, exp_rk(0));
        adv_en = 1'b1;
        for (int t = 1; t <= n; t++) begin
            @(negedge clk);
            chk($sformatf("R4 R7 nk=%0d nb=%0d round %0d", m_nk, m_nb, t),
                rkey, exp_rk(t));
        end
        adv_en = 1'b0;
    endtask

    task automatic t_known_vector();
        build_model(2'd0, 2'd0, KEY_C);
        do_start(2'd0, 2'd0, KEY_C);
        adv_en = 1'b1;
        @(negedge clk);
        chk("R5 published word 4", 256'(rkey[255:224]), 256'(32'ha0fafe17));
        repeat (9) @(negedge clk);
        adv_en = 1'b0;
        chk("R5 published last round key", 256'(rkey[255:128]),
            256'(128'hd014f9a8c9ee2589e13f0cc8b6630ca6));
    endtask

    task automatic t_stall();
        build_model(2'd0, 2'd1, KEY_B);
        do_start(2'd0, 2'd1, KEY_B);
        adv_en = 1'b1;
        repeat (2) @(negedge clk);
        adv_en = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk("R6 held round key", rkey, exp_rk(2));
            chk("R6 held valid", 256'(rkey_valid), 256'(1));
        end
        adv_en = 1'b1;
        @(negedge clk);
        chk("R6 resume after hold", rkey, exp_rk(3));
        adv_en = 1'b0;
    endtask

    task automatic t_sel_ignored();
        build_model(2'd0, 2'd0, KEY_A);
        do_start(2'd0, 2'd0, KEY_A);
        nk_sel = 2'd2;
        nb_sel = 2'd2;
        adv_en = 1'b1;
        for (int t = 1; t <= 3; t++) begin
            @(negedge clk);
            chk("R3 selects changed mid-run ignored", rkey, exp_rk(t));
        end
        adv_en = 1'b0;
    endtask

    task automatic t_restart();
        build_model(2'd2, 2'd2, KEY_A);
        do_start(2'd2, 2'd2, KEY_A);
        adv_en = 1'b1;
        repeat (4) @(negedge clk);
        chk("R8 before restart", rkey, exp_rk(4));
        build_model(2'd1, 2'd0, KEY_B);
        nk_sel = 2'd1; nb_sel = 2'd0; key_in = KEY_B;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8 restart beats advance", rkey, exp_rk(0));
        @(negedge clk);
        chk("R8 advance after restart", rkey, exp_rk(1));
        adv_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        build_sbox();
        t_reset();
        t_pre_start();
        for (int a = 0; a < 3; a++)
            for (int b = 0; b < 3; b++)
                t_run(2'(a), 2'(b), (a + b) % 2 == 0 ? KEY_A : KEY_B, 14);
        t_run(2'd3, 2'd3, KEY_B, 8);   // R3 spare code acts as 8 words
        t_known_vector();
        t_stall();
        t_sel_ignored();
        t_restart();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule